// File: doc/BRIEF.md
# Boost PFC Startup and Fault Sequencer

This block steps a boost power-factor-correction stage through its life cycle: stopped, waiting for the first duty update, ramping the bus up, and running. It does no arithmetic and makes no PWM waveform. It watches start and stop commands, a per-period strobe that marks a freshly computed duty value, the filtered bus voltage against its nominal value, an external "supply healthy" pin and the PWM fault status. From these it drives the PWM enable, the output-override release, the fault-latch mode and a set of one-cycle requests that the control loop acts on.

While the bus is still charging, PWM faults are handled in non-latched mode. Once the bus comes within one eighth of nominal and the external pin is high, the sequencer enters the running state. On that edge it changes to latched fault mode, re-arms the latch and asks the loop to cut its integrator to a quarter. It also keeps sticky flags for a converter fault and for over-temperature, and it reports whether the bus is under or over two thresholds. That report is refreshed on each duty update.

Top module: `pfc_seq_top`

## Requirements
- R1: After reset the state is STOPPED (code 0), and pwm_en, ovr_release, latch_mode, all pulse outputs, both sticky flags and both bus status bits are 0. The state codes are STOPPED=0, STARTWAIT=1, STARTUP=2, RUNNING=3.
- R2: start acts only in STOPPED. On the next clock the state becomes STARTWAIT, pwm_en goes to 1, latch_mode is 0 (non-latched) and arm_init pulses high for exactly one cycle. arm_init asks the loop to clear its integrator and to preset the sample trigger to half the minimum duty. In any other state start has no effect.
- R3: stop or pwm_flt, in any state, sets the state to STOPPED on the next clock and clears pwm_en, ovr_release and latch_mode. Both take priority over start and over the strobe.
- R4: In STARTWAIT the state only changes on the clock after a duty_strobe. That update sets ovr_release to 1 and moves to STARTUP. Without the strobe the state holds.
- R5: On a duty_strobe in STARTWAIT or STARTUP, the state becomes RUNNING when bus_v >= bus_nom - floor(bus_nom/8) and ext_ok is 1. Otherwise it stays in or moves to STARTUP.
- R6: On entry to RUNNING, integ_shift (arithmetic shift right by 2 of the integrator) and latch_rearm each pulse for one cycle. latch_mode is 1 (latched) throughout RUNNING.
- R7: pwm_flt sets flt_conv on the next clock. flt_conv then stays set.
- R8: temp >= temp_lim sets flt_temp on the next clock. flt_temp then stays set.
- R9: flt_clr clears both sticky flags on the next clock, unless the set condition of that flag is present in the same cycle. In that case the flag stays set.
- R10: On a duty_strobe in any state other than STOPPED, bus_low becomes (bus_v < bus_lo_thr) and bus_high becomes (bus_v > bus_hi_thr) on the next clock. In every other cycle both bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command |
| stop | input | 1 | Stop command |
| duty_strobe | input | 1 | One-cycle strobe: new duty value computed |
| bus_v | input | VW | Filtered bus voltage |
| bus_nom | input | VW | Nominal bus voltage |
| ext_ok | input | 1 | External healthy pin (high = ok) |
| pwm_flt | input | 1 | PWM fault status |
| temp | input | TW | Filtered temperature |
| temp_lim | input | TW | Temperature limit |
| bus_lo_thr | input | VW | Bus-low threshold |
| bus_hi_thr | input | VW | Bus-high threshold |
| flt_clr | input | 1 | Clear sticky fault flags |
| state | output | 2 | Sequencer state code |
| pwm_en | output | 1 | PWM output enable |
| ovr_release | output | 1 | Output override released |
| latch_mode | output | 1 | 1 = latched fault mode, 0 = non-latched |
| arm_init | output | 1 | Pulse: clear integrator, preset trigger |
| integ_shift | output | 1 | Pulse: shift integrator right by 2 |
| latch_rearm | output | 1 | Pulse: clear and re-arm fault latch |
| flt_conv | output | 1 | Sticky converter fault |
| flt_temp | output | 1 | Sticky over-temperature |
| bus_low | output | 1 | Bus below low threshold |
| bus_high | output | 1 | Bus above high threshold |

## Verification
Some properties are checked on every cycle: a fault or stop always lands in STOPPED, arm_init only follows STOPPED, and integ_shift only marks a real entry into RUNNING. They also check that STARTWAIT leaves for STARTUP only after a strobe, that the sticky flags never drop without a clear, and that the bus status holds between duty updates. Other behaviour is only shown by the bench scenarios. These are the exact near-nominal threshold, swept over every bus value against ext_ok, the temperature threshold, swept over every value, and the priority of stop over start. They also cover the set-over-clear rule for the flags and the direct path from STARTWAIT to RUNNING.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED   = 2'd0,
        ST_STARTWAIT = 2'd1,
        ST_STARTUP   = 2'd2,
        ST_RUNNING   = 2'd3
    } seq_state_t;

    typedef struct packed {
        seq_state_t state;
        logic       pwm_en;
        logic       ovr_release;
        logic       latch_mode;
        logic       arm_init;
        logic       integ_shift;
        logic       latch_rearm;
    } seq_regs_t;

    typedef struct packed {
        logic flt_conv;
        logic flt_temp;
        logic bus_low;
        logic bus_high;
    } flag_regs_t;

endpackage

// File: rtl/pfc_seq_thresh.sv
module pfc_seq_thresh #(
    parameter int VW        = 10,
    parameter int TW        = 10,
    parameter int NOM_SHIFT = 3
) (
    input  logic [VW-1:0] bus_v,
    input  logic [VW-1:0] bus_nom,
    input  logic [VW-1:0] bus_lo_thr,
    input  logic [VW-1:0] bus_hi_thr,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] temp_lim,
    output logic          near_nom,
    output logic          below_low,
    output logic          above_high,
    output logic          hot
);
    logic [VW-1:0] nom_floor;

    always_comb begin
        // nominal minus its 1/2^NOM_SHIFT share never underflows
        nom_floor  = bus_nom - (bus_nom >> NOM_SHIFT);
        near_nom   = (bus_v >= nom_floor);
        below_low  = (bus_v < bus_lo_thr);
        above_high = (bus_v > bus_hi_thr);
        hot        = (temp >= temp_lim);
    end
endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
    import pfc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       pwm_flt,
    input  logic       duty_strobe,
    input  logic       run_ok,
    output seq_regs_t  regs_q
);
    seq_regs_t regs_d;

    always_comb begin
        regs_d             = regs_q;
        regs_d.arm_init    = 1'b0;
        regs_d.integ_shift = 1'b0;
        regs_d.latch_rearm = 1'b0;
        if (stop || pwm_flt) begin
            regs_d.state       = ST_STOPPED;
            regs_d.pwm_en      = 1'b0;
            regs_d.ovr_release = 1'b0;
            regs_d.latch_mode  = 1'b0;
        end else begin
            unique case (regs_q.state)
                ST_STOPPED: begin
                    if (start) begin
                        regs_d.state      = ST_STARTWAIT;
                        regs_d.pwm_en     = 1'b1;
                        regs_d.arm_init   = 1'b1;
                        regs_d.latch_mode = 1'b0;
                    end
                end
                ST_STARTWAIT: begin
                    if (duty_strobe) begin
                        regs_d.ovr_release = 1'b1;
                        if (run_ok) begin
                            regs_d.state       = ST_RUNNING;
                            regs_d.integ_shift = 1'b1;
                            regs_d.latch_rearm = 1'b1;
                            regs_d.latch_mode  = 1'b1;
                        end else begin
                            regs_d.state = ST_STARTUP;
                        end
                    end
                end
                ST_STARTUP: begin
                    if (duty_strobe && run_ok) begin
                        regs_d.state       = ST_RUNNING;
                        regs_d.integ_shift = 1'b1;
                        regs_d.latch_rearm = 1'b1;
                        regs_d.latch_mode  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R3: stop or fault always lands in STOPPED
    p_fault_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop || pwm_flt) |=> (regs_q.state == ST_STOPPED && !regs_q.pwm_en));

    // R2: arm_init only follows a STOPPED state
    p_start_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.arm_init |-> ($past(regs_q.state) == ST_STOPPED));

    // R6: integ_shift marks a true entry into RUNNING
    p_shift_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.integ_shift |-> (regs_q.state == ST_RUNNING &&
                                $past(regs_q.state) != ST_RUNNING &&
                                regs_q.latch_mode));

    // R4: leaving STARTWAIT for STARTUP needs a strobe
    p_advance_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_STARTUP && $past(regs_q.state) == ST_STARTWAIT)
            |-> $past(duty_strobe));
endmodule

// File: rtl/pfc_seq_flags.sv
module pfc_seq_flags
    import pfc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_flt,
    input  logic       hot,
    input  logic       flt_clr,
    input  logic       upd,
    input  logic       below_low,
    input  logic       above_high,
    output flag_regs_t flags_q
);
    flag_regs_t flags_d;

    always_comb begin
        flags_d          = flags_q;
        flags_d.flt_conv = pwm_flt | (flags_q.flt_conv & ~flt_clr);
        flags_d.flt_temp = hot     | (flags_q.flt_temp & ~flt_clr);
        if (upd) begin
            flags_d.bus_low  = below_low;
            flags_d.bus_high = above_high;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // R7: converter fault is sticky until cleared
    p_conv_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.flt_conv && !flt_clr) |=> flags_q.flt_conv);

    // R8: over-temperature sets the flag next cycle
    p_temp_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> flags_q.flt_temp);

    // R10: bus status holds between duty updates
    p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({flags_q.bus_low, flags_q.bus_high}));
endmodule

// File: rtl/pfc_seq_top.sv
module pfc_seq_top
    import pfc_seq_pkg::*;
#(
    parameter int VW        = 10,
    parameter int TW        = 10,
    parameter int NOM_SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          duty_strobe,
    input  logic [VW-1:0] bus_v,
    input  logic [VW-1:0] bus_nom,
    input  logic          ext_ok,
    input  logic          pwm_flt,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] temp_lim,
    input  logic [VW-1:0] bus_lo_thr,
    input  logic [VW-1:0] bus_hi_thr,
    input  logic          flt_clr,
    output logic [1:0]    state,
    output logic          pwm_en,
    output logic          ovr_release,
    output logic          latch_mode,
    output logic          arm_init,
    output logic          integ_shift,
    output logic          latch_rearm,
    output logic          flt_conv,
    output logic          flt_temp,
    output logic          bus_low,
    output logic          bus_high
);
    logic       near_nom;
    logic       below_low;
    logic       above_high;
    logic       hot;
    logic       run_ok;
    logic       upd;
    seq_regs_t  seq_q;
    flag_regs_t flags_q;

    pfc_seq_thresh #(.VW(VW), .TW(TW), .NOM_SHIFT(NOM_SHIFT)) u_thresh (
        .bus_v      (bus_v),
        .bus_nom    (bus_nom),
        .bus_lo_thr (bus_lo_thr),
        .bus_hi_thr (bus_hi_thr),
        .temp       (temp),
        .temp_lim   (temp_lim),
        .near_nom   (near_nom),
        .below_low  (below_low),
        .above_high (above_high),
        .hot        (hot)
    );

    assign run_ok = near_nom & ext_ok;

    pfc_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .stop        (stop),
        .pwm_flt     (pwm_flt),
        .duty_strobe (duty_strobe),
        .run_ok      (run_ok),
        .regs_q      (seq_q)
    );

    assign upd = duty_strobe & (seq_q.state != ST_STOPPED);

    pfc_seq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_flt    (pwm_flt),
        .hot        (hot),
        .flt_clr    (flt_clr),
        .upd        (upd),
        .below_low  (below_low),
        .above_high (above_high),
        .flags_q    (flags_q)
    );

    assign state       = seq_q.state;
    assign pwm_en      = seq_q.pwm_en;
    assign ovr_release = seq_q.ovr_release;
    assign latch_mode  = seq_q.latch_mode;
    assign arm_init    = seq_q.arm_init;
    assign integ_shift = seq_q.integ_shift;
    assign latch_rearm = seq_q.latch_rearm;
    assign flt_conv    = flags_q.flt_conv;
    assign flt_temp    = flags_q.flt_temp;
    assign bus_low     = flags_q.bus_low;
    assign bus_high    = flags_q.bus_high;

    // R5: RUNNING is only reached with the bus near nominal
    p_run_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && $past(state) != 2'd3) |-> $past(run_ok && duty_strobe));
endmodule

// File: tb/pfc_seq_top_bench.sv
module pfc_seq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 8;
    localparam int TW = 8;
    localparam int NOM = 200;
    localparam int NEAR = NOM - NOM / 8;
    localparam int LO = 100;
    localparam int HI = 230;
    localparam int TLIM = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, stop = 0, duty_strobe = 0, ext_ok = 0, pwm_flt = 0, flt_clr = 0;
    logic [VW-1:0] bus_v = '0;
    logic [TW-1:0] temp = '0;
    logic [1:0] state;
    logic pwm_en, ovr_release, latch_mode, arm_init, integ_shift, latch_rearm;
    logic flt_conv, flt_temp, bus_low, bus_high;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_seq_top #(.VW(VW), .TW(TW)) u_pfc_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .duty_strobe(duty_strobe), .bus_v(bus_v), .bus_nom(8'(NOM)),
        .ext_ok(ext_ok), .pwm_flt(pwm_flt), .temp(temp), .temp_lim(8'(TLIM)),
        .bus_lo_thr(8'(LO)), .bus_hi_thr(8'(HI)), .flt_clr(flt_clr),
        .state(state), .pwm_en(pwm_en), .ovr_release(ovr_release),
        .latch_mode(latch_mode), .arm_init(arm_init), .integ_shift(integ_shift),
        .latch_rearm(latch_rearm), .flt_conv(flt_conv), .flt_temp(flt_temp),
        .bus_low(bus_low), .bus_high(bus_high)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 outputs", {pwm_en, ovr_release, latch_mode, arm_init, integ_shift, latch_rearm}, 0);
        chk("R1 flags", {flt_conv, flt_temp, bus_low, bus_high}, 0);

        // R5/R10 sweep every bus value through a start and a first update
        for (int v = 0; v < 256; v++) begin
            stop = 1; tick(); stop = 0;
            start = 1; tick(); start = 0;
            chk("R2 startwait", state, 1);
            chk("R2 arm_init", arm_init, 1);
            bus_v = 8'(v);
            ext_ok = (v % 3) != 0;
            duty_strobe = 1; tick(); duty_strobe = 0;
            chk("R5 sweep state", state, (v >= NEAR && (v % 3) != 0) ? 3 : 2);
            chk("R10 bus_low", bus_low, (v < LO) ? 1 : 0);
            chk("R10 bus_high", bus_high, (v > HI) ? 1 : 0);
            if (v >= NEAR && (v % 3) != 0) begin
                chk("R6 pulses", {integ_shift, latch_rearm, latch_mode}, 7);
                tick();
                chk("R6 pulse width", {integ_shift, latch_rearm, latch_mode}, 1);
            end
        end

        // R3 stop beats start
        stop = 1; tick(); stop = 0;
        stop = 1; start = 1; tick(); stop = 0; start = 0;
        chk("R3 stop priority", state, 0);
        chk("R3 pwm_en off", pwm_en, 0);
        start = 1; tick(); start = 0;
        chk("R2 pwm_en", pwm_en, 1);
        chk("R2 non-latched", latch_mode, 0);
        tick();
        chk("R2 single pulse", arm_init, 0);
        // R4 hold without strobe even with good bus
        bus_v = 8'd250; ext_ok = 1;
        repeat (5) tick();
        chk("R4 hold", state, 1);
        chk("R4 override held", ovr_release, 0);
        bus_v = 8'd10; duty_strobe = 1; tick(); duty_strobe = 0;
        chk("R4 to startup", state, 2);
        chk("R4 release", ovr_release, 1);
        start = 1; tick(); start = 0;
        chk("R2 ignored state", state, 2);
        chk("R2 ignored pulse", arm_init, 0);
        bus_v = 8'd250; ext_ok = 0; duty_strobe = 1; tick(); duty_strobe = 0;
        chk("R5 ext low", state, 2);
        ext_ok = 1; tick();
        chk("R5 needs strobe", state, 2);
        duty_strobe = 1; tick(); duty_strobe = 0;
        chk("R5 running", state, 3);
        chk("R6 shift", integ_shift, 1);
        // R3/R7 fault in RUNNING
        pwm_flt = 1; tick(); pwm_flt = 0;
        chk("R3 fault stop", state, 0);
        chk("R3 outputs off", {pwm_en, ovr_release, latch_mode}, 0);
        chk("R7 conv set", flt_conv, 1);
        repeat (2) tick();
        chk("R7 sticky", flt_conv, 1);
        // R10 strobe while STOPPED leaves status
        bus_v = 8'd10; duty_strobe = 1; tick(); duty_strobe = 0;
        chk("R10 stopped hold", {bus_low, bus_high}, 1);
        // R9 clear and set-wins
        flt_clr = 1; tick(); flt_clr = 0;
        chk("R9 cleared", flt_conv, 0);
        flt_clr = 1; pwm_flt = 1; tick(); flt_clr = 0; pwm_flt = 0;
        chk("R9 set wins", flt_conv, 1);
        flt_clr = 1; tick(); flt_clr = 0;

        // R8 sweep all temperatures
        for (int t = 0; t < 256; t++) begin
            temp = 8'(t); tick();
            chk("R8 temp flag", flt_temp, (t >= TLIM) ? 1 : 0);
            temp = '0; flt_clr = 1; tick(); flt_clr = 0;
            chk("R9 temp clear", flt_temp, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule